// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block takes one pixel per clock: three 8-bit colour samples and a horizontal sync level. It spreads the samples over two output ports, A and B. In single-port mode every sample lands on port A and port B is not driven. In dual-port mode, consecutive pixels of a line take turns between the ports. The order restarts at every line, and a swap input can reverse it. Dual-port mode has two update styles. In parallel style both ports change together once per pixel pair. In interleaved style exactly one port changes per pixel.

Next to the data, the block produces three signals that keep a receiver aligned with it: a data strobe, which is a clock enable at the output word rate; per-port output enables, which model the high-impedance state of the unused port; and a delayed copy of the sync input. All outputs share one fixed latency, set by a parameter. The three mode inputs are static. They are sampled only at the start of a line, so a line is never split into broken pairs.

Top module: `pxd_demux`

## Requirements
- R1: A line starts on a clock where `sync_in` is 1 and was 0 on the previous clock; the pixel presented on that clock is pixel 0 of the line.
- R2: After reset, `oe_a` is 1 on every output word. `oe_b` is 1 only for words produced in dual-port mode and is 0 in single-port mode.
- R3: In single-port mode, every pixel appears on `port_a` and `data_stb` is 1 on every output word.
- R4: In dual-port mode with `swap_ab`=0, the even pixels of a line (0, 2, 4, …) go to port A and the odd pixels go to port B.
- R5: With `swap_ab`=1, the ports are exchanged: even pixels go to port B and odd pixels go to port A.
- R6: In dual parallel mode (`par_mode`=1), both ports change together on the odd pixel of each pair. The held even pixel goes to its port and the odd pixel goes to the other port. Neither port changes on an even pixel.
- R7: In dual interleaved mode (`par_mode`=0), each pixel updates only its own port. The other port keeps its value.
- R8: In dual-port mode, `data_stb` is 1 only for the output word of an odd pixel, which gives half the pixel rate with one strobe per pair.
- R9: Data, strobe, output enables and `sync_out` appear exactly LATENCY clocks after the pixel is presented. `sync_out` reproduces `sync_in` with that delay.
- R10: `dual_mode`, `par_mode` and `swap_ab` are sampled only on the first pixel of a line. A change in mid-line has no effect until the next line start.
- R11: A synchronous active-high reset does the following:
  - clears both ports, the strobe, the enables and `sync_out` to 0;
  - selects single-port mode until the first line start;
  - makes the next pixel pixel 0 of a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | N_CH*CH_W | One pixel, channel 0 in the low bits |
| sync_in | input | 1 | Horizontal sync level; a rising level starts a line |
| dual_mode | input | 1 | 1 = dual-port, 0 = single-port |
| par_mode | input | 1 | In dual-port mode: 1 = parallel, 0 = interleaved |
| swap_ab | input | 1 | 1 = even pixels go to port B |
| port_a | output | N_CH*CH_W | Port A data |
| port_b | output | N_CH*CH_W | Port B data |
| oe_a | output | 1 | Port A drive enable |
| oe_b | output | 1 | Port B drive enable |
| data_stb | output | 1 | Output word clock enable |
| sync_out | output | 1 | Sync aligned with the data |

## Verification
Every output is due exactly LATENCY clocks after the pixel that caused it, in every mode, including the sync copy and the strobe. The bench keeps LATENCY slots of expected output words. Each cycle it compares the design's outputs with the oldest slot, pushes a new word computed from that cycle's drive, and samples on the falling edge. A reset empties the slots to zero, because the design's delay line is cleared in the same clock.

// File: rtl/pxd_pkg.sv
package pxd_pkg;
   // Line-level configuration captured at each line start
   typedef struct packed {
      logic dual;
      logic par;
      logic swap;
   } pxd_mode_t;
endpackage

// File: rtl/pxd_delay.sv
module pxd_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (DEPTH == 0) begin : g_wire
         assign q = d;
      end else begin : g_regs
         logic [W-1:0] stg [DEPTH];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/pxd_line_ctrl.sv
module pxd_line_ctrl
   import pxd_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      sync_in,
   input  pxd_mode_t mode_in,
   output pxd_mode_t mode_now,
   output logic      second,
   output logic      to_b,
   output logic      stg_sync,
   output logic      stg_stb,
   output logic      stg_oe_a,
   output logic      stg_oe_b
);
   logic      sync_q;
   logic      line_go;
   pxd_mode_t mode_q;
   logic      odd_q;

   assign line_go  = sync_in & ~sync_q;
   assign mode_now = line_go ? mode_in : mode_q;
   assign second   = line_go ? 1'b0 : odd_q;
   assign to_b     = second ^ mode_now.swap;
   assign stg_sync = sync_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q   <= 1'b0;
         mode_q   <= '0;
         odd_q    <= 1'b0;
         stg_stb  <= 1'b0;
         stg_oe_a <= 1'b0;
         stg_oe_b <= 1'b0;
      end else begin
         sync_q   <= sync_in;
         mode_q   <= mode_now;
         odd_q    <= mode_now.dual & ~second;
         stg_stb  <= mode_now.dual ? second : 1'b1;
         stg_oe_a <= 1'b1;
         stg_oe_b <= mode_now.dual;
      end
   end
endmodule

// File: rtl/pxd_lane.sv
module pxd_lane #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] pix,
   input  logic         dual,
   input  logic         par,
   input  logic         second,
   input  logic         to_b,
   output logic [W-1:0] out_a,
   output logic [W-1:0] out_b
);
   logic [W-1:0] held;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_a <= '0;
         out_b <= '0;
         held  <= '0;
      end else if (!dual) begin
         out_a <= pix;
      end else if (par) begin
         if (!second) begin
            held <= pix;
         end else if (to_b) begin
            out_a <= held;
            out_b <= pix;
         end else begin
            out_a <= pix;
            out_b <= held;
         end
      end else if (to_b) begin
         out_b <= pix;
      end else begin
         out_a <= pix;
      end
   end
endmodule

// File: rtl/pxd_demux.sv
module pxd_demux
   import pxd_pkg::*;
#(
   parameter int CH_W    = 8,
   parameter int N_CH    = 3,
   parameter int LATENCY = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [N_CH*CH_W-1:0] pix_in,
   input  logic                 sync_in,
   input  logic                 dual_mode,
   input  logic                 par_mode,
   input  logic                 swap_ab,
   output logic [N_CH*CH_W-1:0] port_a,
   output logic [N_CH*CH_W-1:0] port_b,
   output logic                 oe_a,
   output logic                 oe_b,
   output logic                 data_stb,
   output logic                 sync_out
);
   localparam int PW    = N_CH * CH_W;
   localparam int BUS_W = 2 * PW + 4;
   localparam int EXTRA = LATENCY - 1;

   generate
      if (LATENCY < 1) begin : g_bad_lat
         $error("pxd_demux: LATENCY must be at least 1");
      end
      if (CH_W < 1 || N_CH < 1) begin : g_bad_width
         $error("pxd_demux: CH_W and N_CH must be positive");
      end
   endgenerate

   pxd_mode_t mode_in, mode_now;
   logic      second, to_b;
   logic      stg_sync, stg_stb, stg_oe_a, stg_oe_b;
   logic [PW-1:0] stg_a, stg_b;

   assign mode_in = '{dual: dual_mode, par: par_mode, swap: swap_ab};

   pxd_line_ctrl u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .sync_in  (sync_in),
      .mode_in  (mode_in),
      .mode_now (mode_now),
      .second   (second),
      .to_b     (to_b),
      .stg_sync (stg_sync),
      .stg_stb  (stg_stb),
      .stg_oe_a (stg_oe_a),
      .stg_oe_b (stg_oe_b)
   );

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         pxd_lane #(.W(CH_W)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .pix    (pix_in[c*CH_W +: CH_W]),
            .dual   (mode_now.dual),
            .par    (mode_now.par),
            .second (second),
            .to_b   (to_b),
            .out_a  (stg_a[c*CH_W +: CH_W]),
            .out_b  (stg_b[c*CH_W +: CH_W])
         );
      end
   endgenerate

   logic [BUS_W-1:0] bus_d, bus_q;
   assign bus_d = {stg_a, stg_b, stg_oe_a, stg_oe_b, stg_stb, stg_sync};

   pxd_delay #(.W(BUS_W), .DEPTH(EXTRA)) u_align (
      .clk (clk),
      .rst (rst),
      .d   (bus_d),
      .q   (bus_q)
   );

   assign {port_a, port_b, oe_a, oe_b, data_stb, sync_out} = bus_q;
endmodule

// File: rtl/pxd_demux_chk.sv
module pxd_demux_chk #(
   parameter int W = 24
) (
   input logic         clk,
   input logic         rst,
   input logic [W-1:0] port_a,
   input logic [W-1:0] port_b,
   input logic         oe_a,
   input logic         oe_b,
   input logic         data_stb
);
   logic armed = 1'b0;
   always_ff @(posedge clk) if (rst) armed <= 1'b1;

   // R11: reset clears the visible state one clock later
   a_r11_reset_clears: assert property (@(posedge clk)
      rst |=> (port_a == '0 && port_b == '0 && !oe_a && !oe_b && !data_stb));

   // R2: port B is never enabled without port A
   a_r2_b_needs_a: assert property (@(posedge clk) disable iff (rst || !armed)
      oe_b |-> oe_a);

   // R2: once driving, port A stays enabled until reset
   a_r2_a_sticky: assert property (@(posedge clk) disable iff (rst || !armed)
      oe_a |=> oe_a);

   // R3: single-port words always carry the strobe
   a_r3_single_every_word: assert property (@(posedge clk) disable iff (rst || !armed)
      (oe_a && !oe_b) |-> data_stb);

   // R8: two dual-port strobes never come on consecutive words
   a_r8_dual_half_rate: assert property (@(posedge clk) disable iff (rst || !armed)
      (oe_b && data_stb) |=> !(oe_b && data_stb));

   // R7: both ports change together only on a strobed word
   a_r7_one_port_unless_stb: assert property (@(posedge clk) disable iff (rst || !armed)
      (oe_b && !$stable(port_a) && !$stable(port_b)) |-> data_stb);
endmodule

bind pxd_demux pxd_demux_chk #(.W(N_CH*CH_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .port_a   (port_a),
   .port_b   (port_b),
   .oe_a     (oe_a),
   .oe_b     (oe_b),
   .data_stb (data_stb)
);

// File: tb/tb_pxd_demux.sv
module tb_pxd_demux;
   localparam int CH_W = 8;
   localparam int N_CH = 3;
   localparam int LAT  = 2;
   localparam int PW   = N_CH * CH_W;

   typedef struct packed {
      logic [PW-1:0] a;
      logic [PW-1:0] b;
      logic oea, oeb, stb, syn, dual, par;
   } word_t;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst = 1'b1;
   logic [PW-1:0] pix_in = '0;
   logic          sync_in = 1'b0, dual_mode = 1'b0, par_mode = 1'b0, swap_ab = 1'b0;
   logic [PW-1:0] port_a, port_b;
   logic          oe_a, oe_b, data_stb, sync_out;

   pxd_demux #(.CH_W(CH_W), .N_CH(N_CH), .LATENCY(LAT)) dut (
      .clk(clk), .rst(rst), .pix_in(pix_in), .sync_in(sync_in),
      .dual_mode(dual_mode), .par_mode(par_mode), .swap_ab(swap_ab),
      .port_a(port_a), .port_b(port_b), .oe_a(oe_a), .oe_b(oe_b),
      .data_stb(data_stb), .sync_out(sync_out));

   int    n_tests = 0, n_fail = 0;
   bit    armed = 0;
   string force_tag = "";
   word_t expq [LAT];

   // reference state
   logic          m_sprev, m_dual, m_par, m_swap, m_odd;
   logic [PW-1:0] m_hold;
   word_t         m_cur;

   task automatic chk(input string tag, input string what, input logic [PW-1:0] act, input logic [PW-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic string data_tag(input word_t w);
      if (force_tag != "") return force_tag;
      if (!w.dual) return "R3";
      return w.par ? "R6" : "R7";
   endfunction

   function automatic void model_reset();
      m_sprev = 0; m_dual = 0; m_par = 0; m_swap = 0; m_odd = 0; m_hold = '0;
      m_cur = '0;
   endfunction

   function automatic void model_step(input logic [PW-1:0] p, input logic s,
                                      input logic d, input logic pr, input logic sw);
      logic is_odd, dest_b;
      if (s && !m_sprev) begin // R1 line start
         m_dual = d; m_par = pr; m_swap = sw; m_odd = 0;
      end
      is_odd = m_odd;
      dest_b = is_odd ? !m_swap : m_swap;
      m_cur.oea = 1; m_cur.oeb = m_dual; m_cur.syn = s;
      m_cur.dual = m_dual; m_cur.par = m_par;
      if (!m_dual) begin
         m_cur.a = p; m_cur.stb = 1;
      end else begin
         m_cur.stb = is_odd;
         if (m_par) begin
            if (!is_odd) m_hold = p;
            else if (dest_b) begin m_cur.a = m_hold; m_cur.b = p; end
            else begin m_cur.a = p; m_cur.b = m_hold; end
         end else if (dest_b) m_cur.b = p;
         else m_cur.a = p;
      end
      m_odd = m_dual && !is_odd;
      m_sprev = s;
   endfunction

   task automatic step(input logic r, input logic [PW-1:0] p, input logic s,
                       input logic d, input logic pr, input logic sw);
      word_t e;
      @(negedge clk);
      if (armed) begin
         e = expq[LAT-1];
         chk(data_tag(e), "port_a", port_a, e.a);
         chk(data_tag(e), "port_b", port_b, e.b);
         chk(force_tag != "" ? force_tag : "R2", "oe", {oe_a, oe_b}, {e.oea, e.oeb});
         chk(force_tag != "" ? force_tag : (e.dual ? "R8" : "R3"), "data_stb", data_stb, e.stb);
         chk("R9", "sync_out", sync_out, e.syn);
      end
      rst = r; pix_in = p; sync_in = s; dual_mode = d; par_mode = pr; swap_ab = sw;
      if (r) begin
         model_reset();
         for (int i = 0; i < LAT; i++) expq[i] = '0;
      end else begin
         model_step(p, s, d, pr, sw);
         for (int i = LAT-1; i > 0; i--) expq[i] = expq[i-1];
         expq[0] = m_cur;
      end
      armed = 1;
   endtask

   task automatic line(input int len, input int sw_len, input logic d, input logic pr, input logic sw);
      for (int i = 0; i < len; i++)
         step(0, PW'($urandom), i < sw_len, d, pr, sw);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      model_reset();
      for (int i = 0; i < 4; i++) step(1, '0, 0, 1, 1, 1);
      // R11: reset state, and single-port mode before the first line start
      force_tag = "R11";
      for (int i = 0; i < LAT + 2; i++) step(0, PW'($urandom), 0, 1, 1, 0);
      force_tag = "";
      // R1/R3: single-port line
      line(20, 1, 0, 0, 0);
      // R10: mid-line change to dual-port has no effect until the next line
      force_tag = "R10";
      line(6, 1, 0, 0, 0);
      line(8, 0, 1, 1, 1);
      force_tag = "";
      // R4/R7: interleaved, no swap, odd and even line lengths
      force_tag = "R4"; line(11, 2, 1, 0, 0); line(10, 1, 1, 0, 0);
      // R5: swapped order
      force_tag = "R5"; line(9, 1, 1, 0, 1); line(12, 3, 1, 1, 1);
      force_tag = "";
      // R6: parallel, both orders
      line(13, 1, 1, 1, 0); line(14, 2, 1, 1, 1);
      // random lines in every mode
      for (int k = 0; k < 60; k++)
         line(3 + int'($urandom_range(40)), 1 + int'($urandom_range(2)),
              logic'($urandom_range(1)), logic'($urandom_range(1)), logic'($urandom_range(1)));
      // R11: reset in mid-stream
      line(5, 1, 1, 1, 0);
      step(1, '0, 0, 1, 1, 0);
      force_tag = "R11";
      for (int i = 0; i < LAT + 1; i++) step(0, PW'($urandom), 0, 1, 0, 0);
      force_tag = "";
      line(10, 1, 1, 0, 1);
      for (int i = 0; i < LAT + 1; i++) step(0, '0, 0, 0, 0, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule